// File: doc/BRIEF.md
# Two-Level Page Table Walker with Bus Arbiter

This block turns a virtual page number into a physical frame when the translation cache misses. It does this in hardware alone. A miss request carries the virtual page number, a write flag and a user flag. The walker reads the directory entry and then the table entry over a single shared memory port. It merges the permission bits of the two levels. When the access is legal, it sets the Accessed and Dirty bits in memory. It then returns either a fill for the translation cache or a fault code.

A fixed-priority arbiter sits in the same block. It shares the memory port among three requesters: the walker, a data requester and an instruction prefetcher. When paging is switched off, a miss comes back on the next cycle as an identity mapping, and no memory traffic is made.

Top module: `pw_top`

## Requirements
- R1: With `pg_en` low at acceptance, `resp_valid` rises on the cycle after the miss is accepted, with `resp_frame` equal to the virtual page number, `resp_fault`=0, `resp_user`=`resp_wr`=1, and no memory transfer.
- R2: The directory entry is read at `{pdbr,12'b0} + vpn[19:10]*4`. The table entry is read at `{pde[31:12],12'b0} + vpn[9:0]*4`.
- R3: The directory entry is read before the table entry. A directory entry with bit 0 (present) clear ends the walk without reading the table.
- R4: If either entry has bit 0 clear, the result is a fault with `resp_code`={user,write,0}, and no memory write is made.
- R5: Effective user permission is the AND of bit 2 of both entries, and effective write permission is the AND of bit 1 of both entries. A user access without user permission, or a user write without write permission, faults with `resp_code`={user,write,1} and writes nothing. Supervisor accesses to present pages never fault. A fill reports the combined bits on `resp_user`/`resp_wr` and the table frame on `resp_frame`.
- R6: On a successful walk, bit 5 (accessed) is written as 1 only into an entry where it was clear. The directory write comes before the table write.
- R7: Bit 6 (dirty) is set only in the table entry, and only on a write access where it was clear. Such an entry is written back even if its accessed bit was already set.
- R8: The grant priority is fixed: walker first, then data, then prefetch. At most one grant is active.
- R9: A grant, and the address it drives, stay stable until `mem_ready` completes the transfer.
- R10: `resp_valid` is a one-cycle pulse. `miss_ready` is high only while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_en | input | 1 | Paging enable |
| pdbr | input | 20 | Frame number of the page directory |
| miss_valid | input | 1 | Miss request |
| miss_ready | output | 1 | Walker idle, miss accepted |
| miss_vpn | input | 20 | Virtual page number of the miss |
| miss_write | input | 1 | Miss is a write access |
| miss_user | input | 1 | Miss is a user-mode access |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Result is a page fault |
| resp_frame | output | 20 | Physical frame of the fill |
| resp_user | output | 1 | Combined user permission |
| resp_wr | output | 1 | Combined write permission |
| resp_code | output | 3 | Fault code {user, write, protection} |
| d_req | input | 1 | Data requester bus request |
| d_we | input | 1 | Data requester write |
| d_addr | input | 32 | Data requester address |
| d_wdata | input | 32 | Data requester write data |
| d_gnt | output | 1 | Data requester owns the bus |
| d_done | output | 1 | Data transfer completes |
| pf_req | input | 1 | Prefetch bus request |
| pf_addr | input | 32 | Prefetch address |
| pf_gnt | output | 1 | Prefetch owns the bus |
| pf_done | output | 1 | Prefetch transfer completes |
| mem_valid | output | 1 | Memory transfer active |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory completes transfer |
| mem_rdata | input | 32 | Memory read data |

## Verification
Random entry pairs are walked under all four combinations of user and write, with present, permission, accessed and dirty bits drawn at random. Each case separates the fault, fill and writeback outcomes and checks the entry images left in memory. Directed walks cover these cases: a missing directory entry (which must not read the table), a missing table entry, a supervisor write to a read-only page, and entries whose accessed and dirty bits are already set (which must make no writes). A flat-mode miss shows the single-cycle identity path. Contention tests raise data and prefetch requests during a walk and on an idle bus, to tell the fixed priority order from simple arrival order. Random memory latency exercises grant holding.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    WS_IDLE, WS_DIR_RD, WS_TBL_RD, WS_DIR_WB, WS_TBL_WB
  } walk_state_e;

  localparam int BIT_P = 0;
  localparam int BIT_W = 1;
  localparam int BIT_U = 2;
  localparam int BIT_A = 5;
  localparam int BIT_D = 6;
endpackage

// File: rtl/pw_arb.sv
module pw_arb #(
  parameter int NREQ = 3,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREQ-1:0]          req,
  input  logic [NREQ-1:0]          we,
  input  logic [NREQ-1:0][AW-1:0]  addr,
  input  logic [NREQ-1:0][DW-1:0]  wdata,
  output logic [NREQ-1:0]          gnt,
  output logic [NREQ-1:0]          done,
  output logic                     mem_valid,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  input  logic                     mem_ready
);
  logic [NREQ-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gnt <= '0;
    else if (|gnt) begin
      if (mem_ready) gnt <= '0;
    end else gnt <= pick;
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (gnt[i]) begin
        mem_we    = we[i];
        mem_addr  = addr[i];
        mem_wdata = wdata[i];
      end
    end
  end

  assign mem_valid = |gnt;
  assign done      = gnt & {NREQ{mem_ready}};

  a_r8_single_grant: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  a_r8_first_wins: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req[0]) |=> gnt[0]);
  a_r8_data_before_pf: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && !req[0] && req[1]) |=> gnt[1]);
  a_r9_grant_held: assert property (@(posedge clk) disable iff (rst)
    (|gnt && !mem_ready) |=> $stable(gnt));
endmodule

// File: rtl/pw_walk.sv
module pw_walk
  import pw_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pg_en,
  input  logic [PA_W-OFF_W-1:0]  pdbr,
  input  logic                   miss_valid,
  output logic                   miss_ready,
  input  logic [DIR_W+TBL_W-1:0] miss_vpn,
  input  logic                   miss_write,
  input  logic                   miss_user,
  output logic                   resp_valid,
  output logic                   resp_fault,
  output logic [PA_W-OFF_W-1:0]  resp_frame,
  output logic                   resp_user,
  output logic                   resp_wr,
  output logic [2:0]             resp_code,
  output logic                   walk_req,
  output logic                   walk_we,
  output logic [PA_W-1:0]        walk_addr,
  output logic [PA_W-1:0]        walk_wdata,
  input  logic                   walk_done,
  input  logic [PA_W-1:0]        bus_rdata
);
  localparam int FR_W = PA_W - OFF_W;
  localparam int VPN_W = DIR_W + TBL_W;

  walk_state_e         state;
  logic [VPN_W-1:0]    vpn_q;
  logic [FR_W-1:0]     base_q;
  logic                wr_q, usr_q;
  logic [PA_W-1:0]     pde, pte;
  logic [PA_W-1:0]     tbl_cur, dir_addr, tbl_addr;
  logic                eff_u, eff_w, tbl_needs_wb;

  assign miss_ready = (state == WS_IDLE);
  assign tbl_cur    = (state == WS_TBL_RD) ? bus_rdata : pte;
  assign eff_u      = pde[BIT_U] & tbl_cur[BIT_U];
  assign eff_w      = pde[BIT_W] & tbl_cur[BIT_W];
  assign tbl_needs_wb = !tbl_cur[BIT_A] || (wr_q && !tbl_cur[BIT_D]);
  assign dir_addr = {base_q, {OFF_W{1'b0}}} + (PA_W'(vpn_q[VPN_W-1 -: DIR_W]) << 2);
  assign tbl_addr = {pde[PA_W-1:OFF_W], {OFF_W{1'b0}}} + (PA_W'(vpn_q[TBL_W-1:0]) << 2);

  always_comb begin
    walk_req   = 1'b0;
    walk_we    = 1'b0;
    walk_addr  = tbl_addr;
    walk_wdata = '0;
    case (state)
      WS_DIR_RD: begin walk_req = 1'b1; walk_addr = dir_addr; end
      WS_TBL_RD: walk_req = 1'b1;
      WS_DIR_WB: begin
        walk_req = 1'b1; walk_we = 1'b1; walk_addr = dir_addr;
        walk_wdata = pde | (PA_W'(1) << BIT_A);
      end
      WS_TBL_WB: begin
        walk_req = 1'b1; walk_we = 1'b1;
        walk_wdata = pte | (PA_W'(1) << BIT_A) | (PA_W'(wr_q) << BIT_D);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WS_IDLE;
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_frame <= '0;
      resp_user  <= 1'b0;
      resp_wr    <= 1'b0;
      resp_code  <= '0;
      vpn_q      <= '0;
      base_q     <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      pde        <= '0;
      pte        <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        WS_IDLE: if (miss_valid) begin
          vpn_q  <= miss_vpn;
          base_q <= pdbr;
          wr_q   <= miss_write;
          usr_q  <= miss_user;
          if (!pg_en) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b0;
            resp_frame <= FR_W'(miss_vpn);
            resp_user  <= 1'b1;
            resp_wr    <= 1'b1;
            resp_code  <= '0;
          end else state <= WS_DIR_RD;
        end
        WS_DIR_RD: if (walk_done) begin
          pde <= bus_rdata;
          if (!bus_rdata[BIT_P]) begin
            state <= WS_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b1;
            resp_code <= {usr_q, wr_q, 1'b0};
          end else state <= WS_TBL_RD;
        end
        WS_TBL_RD: if (walk_done) begin
          pte <= bus_rdata;
          if (!bus_rdata[BIT_P]) begin
            state <= WS_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b1;
            resp_code <= {usr_q, wr_q, 1'b0};
          end else if (usr_q && (!eff_u || (wr_q && !eff_w))) begin
            state <= WS_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b1;
            resp_code <= {usr_q, wr_q, 1'b1};
          end else if (!pde[BIT_A]) state <= WS_DIR_WB;
          else if (tbl_needs_wb) state <= WS_TBL_WB;
          else begin
            state <= WS_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b0;
            resp_frame <= bus_rdata[PA_W-1:OFF_W]; resp_user <= eff_u;
            resp_wr <= eff_w; resp_code <= '0;
          end
        end
        WS_DIR_WB: if (walk_done) begin
          if (tbl_needs_wb) state <= WS_TBL_WB;
          else begin
            state <= WS_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b0;
            resp_frame <= pte[PA_W-1:OFF_W]; resp_user <= eff_u;
            resp_wr <= eff_w; resp_code <= '0;
          end
        end
        WS_TBL_WB: if (walk_done) begin
          state <= WS_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b0;
          resp_frame <= pte[PA_W-1:OFF_W]; resp_user <= eff_u;
          resp_wr <= eff_w; resp_code <= '0;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  a_r1_flat_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (state == WS_IDLE && miss_valid && !pg_en) |=> (resp_valid && !walk_req));
  a_r4_fault_after_read: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> $past(walk_req && !walk_we));
  a_r3_table_after_dir: assert property (@(posedge clk) disable iff (rst)
    (state == WS_TBL_RD && $past(state) != WS_TBL_RD) |-> $past(state) == WS_DIR_RD);
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (rst)
    (miss_ready && miss_valid && pg_en) |=> !miss_ready);
endmodule

// File: rtl/pw_top.sv
module pw_top #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pg_en,
  input  logic [PA_W-OFF_W-1:0]  pdbr,
  input  logic                   miss_valid,
  output logic                   miss_ready,
  input  logic [DIR_W+TBL_W-1:0] miss_vpn,
  input  logic                   miss_write,
  input  logic                   miss_user,
  output logic                   resp_valid,
  output logic                   resp_fault,
  output logic [PA_W-OFF_W-1:0]  resp_frame,
  output logic                   resp_user,
  output logic                   resp_wr,
  output logic [2:0]             resp_code,
  input  logic                   d_req,
  input  logic                   d_we,
  input  logic [PA_W-1:0]        d_addr,
  input  logic [PA_W-1:0]        d_wdata,
  output logic                   d_gnt,
  output logic                   d_done,
  input  logic                   pf_req,
  input  logic [PA_W-1:0]        pf_addr,
  output logic                   pf_gnt,
  output logic                   pf_done,
  output logic                   mem_valid,
  output logic                   mem_we,
  output logic [PA_W-1:0]        mem_addr,
  output logic [PA_W-1:0]        mem_wdata,
  input  logic                   mem_ready,
  input  logic [PA_W-1:0]        mem_rdata
);
  localparam int NREQ = 3;

  logic            walk_req, walk_we;
  logic [PA_W-1:0] walk_addr, walk_wdata;
  logic [NREQ-1:0] gnt, done;

  pw_walk #(.PA_W(PA_W), .OFF_W(OFF_W), .DIR_W(DIR_W), .TBL_W(TBL_W)) u_walk (
    .clk, .rst, .pg_en, .pdbr, .miss_valid, .miss_ready, .miss_vpn,
    .miss_write, .miss_user, .resp_valid, .resp_fault, .resp_frame,
    .resp_user, .resp_wr, .resp_code, .walk_req, .walk_we, .walk_addr,
    .walk_wdata, .walk_done(done[0]), .bus_rdata(mem_rdata)
  );

  pw_arb #(.NREQ(NREQ), .AW(PA_W), .DW(PA_W)) u_arb (
    .clk, .rst,
    .req({pf_req, d_req, walk_req}),
    .we({1'b0, d_we, walk_we}),
    .addr({pf_addr, d_addr, walk_addr}),
    .wdata({{PA_W{1'b0}}, d_wdata, walk_wdata}),
    .gnt, .done, .mem_valid, .mem_we, .mem_addr, .mem_wdata, .mem_ready
  );

  assign d_gnt   = gnt[1];
  assign d_done  = done[1];
  assign pf_gnt  = gnt[2];
  assign pf_done = done[2];
endmodule

// File: tb/pw_top_tb.sv
module pw_top_tb;
  logic clk = 0, rst = 1;
  logic pg_en = 1;
  logic [19:0] pdbr = 20'd0;
  logic miss_valid = 0, miss_write = 0, miss_user = 0;
  logic [19:0] miss_vpn = '0;
  logic miss_ready, resp_valid, resp_fault, resp_user, resp_wr;
  logic [19:0] resp_frame;
  logic [2:0] resp_code;
  logic d_req = 0, d_we = 0, pf_req = 0;
  logic [31:0] d_addr = '0, d_wdata = '0, pf_addr = '0;
  logic d_gnt, d_done, pf_gnt, pf_done;
  logic mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  pw_top u_dut (.*);

  logic [31:0] mem [0:4095];
  int wr_cnt, bus_cyc;
  logic [1:0] lat;
  logic [31:0] rd_log [0:1];
  int rd_n;
  int n_chk = 0, n_bad = 0;

  always @(posedge clk) begin
    if (rst) begin mem_ready <= 0; mem_rdata <= '0; lat <= 0; end
    else if (mem_valid && !mem_ready) begin
      bus_cyc = bus_cyc + 1;
      if (lat == 0) begin
        mem_ready <= 1;
        if (mem_we) begin mem[mem_addr[13:2]] = mem_wdata; wr_cnt = wr_cnt + 1; end
        else mem_rdata <= mem[mem_addr[13:2]];
        lat <= 2'($urandom % 3);
      end else lat <= lat - 1;
    end else mem_ready <= 0;
  end

  task automatic check(input bit ok, input string tag, input [31:0] act, input [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_walk(input [31:0] pde, input [31:0] pte, input bit wr, input bit usr,
      output bit fault, output [2:0] code, output bit u, output bit w,
      output [31:0] npde, output [31:0] npte, output int nwr);
    npde = pde; npte = pte; nwr = 0; fault = 0; code = 0;
    u = pde[2] & pte[2]; w = pde[1] & pte[1];
    if (!pde[0] || !pte[0]) begin fault = 1; code = {usr, wr, 1'b0}; end
    else if (usr && (!u || (wr && !w))) begin fault = 1; code = {usr, wr, 1'b1}; end
    else begin
      if (!pde[5]) begin npde[5] = 1; nwr++; end
      if (!pte[5] || (wr && !pte[6])) begin npte[5] = 1; if (wr) npte[6] = 1; nwr++; end
    end
  endtask

  task automatic walk_case(input [19:0] vpn, input [31:0] pde, input [31:0] pte,
      input bit wr, input bit usr, input string tag);
    bit ef, eu, ew; logic [2:0] ec; logic [31:0] npde, npte; int nwr;
    int di, ti, cyc;
    di = int'(vpn[19:10]);
    ti = int'(pde[13:12]) * 1024 + int'(vpn[9:0]);
    mem[di] = pde;
    if (pde[0]) mem[ti] = pte;
    expect_walk(pde, pte, wr, usr, ef, ec, eu, ew, npde, npte, nwr);
    wr_cnt = 0; rd_n = 0;
    @(negedge clk);
    miss_vpn = vpn; miss_write = wr; miss_user = usr; miss_valid = 1;
    @(negedge clk);
    miss_valid = 0;
    cyc = 0;
    while (!resp_valid && cyc < 200) begin
      @(posedge clk); #1;
      if (mem_valid && mem_ready && !mem_we && rd_n < 2) begin rd_log[rd_n] = mem_addr; rd_n++; end
      @(negedge clk); cyc++;
    end
    check(resp_valid, {tag, " R10 response"}, 32'(resp_valid), 1);
    check(resp_fault == ef, {tag, " R4 R5 fault"}, 32'(resp_fault), 32'(ef));
    if (ef) check(resp_code == ec, {tag, " R4 R5 code"}, 32'(resp_code), 32'(ec));
    else begin
      check(resp_frame == pte[31:12], {tag, " R5 frame"}, 32'(resp_frame), 32'(pte[31:12]));
      check({resp_user, resp_wr} == {eu, ew}, {tag, " R5 perms"}, 32'({resp_user, resp_wr}), 32'({eu, ew}));
    end
    check(rd_log[0] == 32'(di * 4), {tag, " R2 dir addr"}, rd_log[0], 32'(di * 4));
    if (pde[0]) check(rd_n == 2 && rd_log[1] == 32'(ti * 4), {tag, " R2 R3 table addr"}, rd_log[1], 32'(ti * 4));
    else check(rd_n == 1, {tag, " R3 no table read"}, 32'(rd_n), 1);
    check(wr_cnt == nwr, {tag, " R6 R7 write count"}, 32'(wr_cnt), 32'(nwr));
    check(mem[di] == npde, {tag, " R6 dir image"}, mem[di], npde);
    if (pde[0]) check(mem[ti] == npte, {tag, " R6 R7 table image"}, mem[ti], npte);
    @(negedge clk);
    check(!resp_valid && miss_ready, {tag, " R10 pulse"}, 32'(resp_valid), 0);
  endtask

  function automatic logic [31:0] rnd_entry();
    logic [31:0] e;
    e = $urandom;
    e[31:12] = 20'(1 + $urandom % 3);
    e[0] = ($urandom % 8) != 0;
    return e;
  endfunction

  initial begin
    int bc; int first; int cyc;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    wr_cnt = 0; bus_cyc = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(miss_ready && !resp_valid && !mem_valid, "R10 reset state", 32'({miss_ready, resp_valid, mem_valid}), 32'b100);

    // R1: flat mode
    pg_en = 0; bc = bus_cyc;
    miss_vpn = 20'hABCDE; miss_valid = 1;
    @(negedge clk);
    miss_valid = 0;
    check(resp_valid && !resp_fault && resp_frame == 20'hABCDE && resp_user && resp_wr,
          "R1 flat identity", 32'(resp_frame), 32'hABCDE);
    @(negedge clk);
    check(bus_cyc == bc && !resp_valid, "R1 no bus traffic", 32'(bus_cyc - bc), 0);
    pg_en = 1;

    // Directed corners
    walk_case(20'h00403, 32'h0000_1066, 32'h0002_3007, 0, 1, "dir absent");
    walk_case(20'h00805, 32'h0000_2007, 32'h0003_3006, 1, 0, "table absent");
    walk_case(20'h00c07, 32'h0000_3003, 32'h0005_3007, 0, 1, "user on supervisor R5");
    walk_case(20'h01009, 32'h0000_1005, 32'h0006_3007, 1, 1, "user write ro R5");
    walk_case(20'h0140b, 32'h0000_2005, 32'h0007_3001, 1, 0, "supervisor write ro R5");
    walk_case(20'h0180d, 32'h0000_3027, 32'h0008_3067, 1, 1, "all set R6 R7");
    walk_case(20'h01c0f, 32'h0000_1027, 32'h0009_3027, 1, 1, "dirty only R7");
    walk_case(20'h02011, 32'h0000_2007, 32'h000A_3007, 0, 1, "read both A R6");

    // Random walks
    for (int k = 0; k < 120; k++)
      walk_case(20'($urandom), rnd_entry(), rnd_entry(), 1'($urandom), 1'($urandom), "random");

    // R8: walker beats data and prefetch during a walk
    mem[1] = 32'h0000_1027; mem[1024 + 2] = 32'h0000_5067;
    d_addr = 32'h0000_3000; pf_addr = 32'h0000_3004;
    @(negedge clk);
    miss_vpn = 20'h00402; miss_write = 0; miss_user = 0; miss_valid = 1;
    @(negedge clk);
    miss_valid = 0; d_req = 1; pf_req = 1; first = 0; cyc = 0;
    while ((d_req || pf_req) && cyc < 300) begin
      if (resp_valid && first == 0) first = 3;
      if (d_done) begin if (first == 0) first = 1; d_req = 0; end
      if (pf_done) begin if (first == 0) first = 2; pf_req = 0; end
      if (d_gnt) check(mem_addr == d_addr, "R9 data address held", mem_addr, d_addr);
      @(negedge clk); cyc++;
    end
    check(first == 3, "R8 walker served first", 32'(first), 3);

    // R8: data over prefetch on idle bus
    repeat (2) @(negedge clk);
    d_req = 1; pf_req = 1;
    @(negedge clk);
    check(d_gnt && !pf_gnt, "R8 data before prefetch", 32'({d_gnt, pf_gnt}), 32'b10);
    first = 0; cyc = 0;
    while ((d_req || pf_req) && cyc < 100) begin
      if (d_done) begin if (first == 0) first = 1; d_req = 0; end
      if (pf_done) begin if (first == 0) first = 2; pf_req = 0; end
      if (pf_gnt) check(mem_addr == pf_addr, "R9 prefetch address held", mem_addr, pf_addr);
      @(negedge clk); cyc++;
    end
    check(first == 1, "R8 data completes first", 32'(first), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule